// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit sits next to a small 8-bit processor that drives a 16-bit address bus. Software loads a 16-bit compare address, split over two byte-wide registers, and sets an enable bit in a status and control register. The unit then watches every valid cycle on the processor address bus. When that address equals the compare address while the unit is enabled, it asks the processor for a break interrupt. The request waits until the current instruction ends, unless the match falls on the last cycle of that instruction. In that case the request is raised at once.

The processor acknowledges the request with a handshake. The acknowledge sets a break-active flag, and that flag freezes the timer counter for as long as it is set. The unit also supplies the address of the break vector, which differs in monitor mode. Software may clear the break-active flag only when an external flag-clear-enable input allows it. In stop mode the unit does not raise breaks but keeps its registers. In wait mode it stays active, and a break that ends the wait gives a one-cycle wake pulse.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, the compare-high, compare-low and status registers all read 0x00, and brk_req and timer_freeze are 0.
- R2: The compare-high byte is at address 0xFE0C and the compare-low byte is at 0xFE0D. The status register is at 0xFE0E, with enable in bit 7, break-active in bit 6, and bits 5 to 0 always reading 0. A read of any other address returns 0x00. Read data is valid in the cycle of a read access.
- R3: With enable set, a valid bus address equal to the compare address in a cycle with instr_last=1 makes brk_req 1 in the next cycle.
- R4: A match in a cycle with instr_last=0 (and wait_mode=0) raises no request until the next cycle with instr_last=1. brk_req then becomes 1 in the cycle after that one.
- R5: With enable clear, a match never raises brk_req.
- R6: brk_req stays 1 until a cycle with brk_ack=1 and is 0 in the cycle after it. That acknowledge sets break-active, and timer_freeze equals break-active.
- R7: Writing the status register with bit 6 = 0 clears break-active only when flag_clr_en=1. Writing bit 6 = 1 never sets it.
- R8: While stop_mode=1, no request is raised, a pending deferred match is discarded, and the register contents are kept.
- R9: While wait_mode=1, a match counts as an instruction boundary: brk_req rises in the next cycle. wake_pulse is 1 in that same cycle only.
- R10: vec_addr is 0xFFFC when monitor_mode=0 and 0xFEFC when monitor_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not reading a mapped register) |
| cpu_addr | input | 16 | Processor address bus being watched |
| cpu_valid | input | 1 | cpu_addr carries a real bus cycle |
| instr_last | input | 1 | Current cycle is the last one of an instruction |
| brk_ack | input | 1 | Processor takes the break request |
| monitor_mode | input | 1 | Selects the monitor break vector |
| wait_mode | input | 1 | Processor is in wait mode |
| stop_mode | input | 1 | Processor is in stop mode |
| flag_clr_en | input | 1 | Allows clearing break-active by software |
| brk_req | output | 1 | Break interrupt request |
| vec_addr | output | 16 | Break vector address |
| timer_freeze | output | 1 | Stops the timer counter |
| wake_pulse | output | 1 | One-cycle pulse when a break ends wait mode |

## Verification
The assertions assume that the processor raises brk_ack only when a request is present, and that stop_mode and wait_mode are never 1 together. The bench drives brk_ack only in cycles where it has already seen brk_req high. It keeps the two mode inputs exclusive. It changes instr_last only in cycles where it means an instruction to end.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    // Field positions inside the status register, counted from the MSB.
    localparam int STAT_EN_FROM_TOP  = 0;
    localparam int STAT_ACT_FROM_TOP = 1;

    // Compare-match sequencing state.
    typedef struct packed {
        logic pend;
        logic req;
        logic wake;
    } trig_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs #(
    parameter int                  ADDR_W    = 16,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   BASE_ADDR = 16'hFE0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              set_active,
    input  logic              flag_clr_en,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic              en,
    output logic              active
);
    import bkpt_pkg::*;

    localparam int NUM_BYTES = ADDR_W / DATA_W;
    localparam int EN_BIT    = DATA_W - 1 - STAT_EN_FROM_TOP;
    localparam int ACT_BIT   = DATA_W - 1 - STAT_ACT_FROM_TOP;
    localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(NUM_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] cmp;
        logic              en;
        logic              active;
    } regs_t;

    regs_t q, d;

    logic [NUM_BYTES-1:0] byte_hit;
    logic                 stat_hit;

    // One decoder per compare byte; byte 0 is the most significant.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BYTES; gi++) begin : g_dec
            localparam logic [ADDR_W-1:0] HIT_A = BASE_ADDR + ADDR_W'(gi);
            assign byte_hit[gi] = bus_sel && (bus_addr == HIT_A);
        end
    endgenerate
    assign stat_hit = bus_sel && (bus_addr == STAT_ADDR);

    always_comb begin
        d = q;
        if (bus_wr) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (byte_hit[i]) begin
                    d.cmp[ADDR_W-1-i*DATA_W -: DATA_W] = bus_wdata;
                end
            end
            if (stat_hit) begin
                d.en = bus_wdata[EN_BIT];
                // Clearing the active flag is blocked while it is set
                // unless the protection input allows it.
                if (!bus_wdata[ACT_BIT] && (flag_clr_en || !q.active)) begin
                    d.active = 1'b0;
                end
            end
        end
        if (set_active) begin
            d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (byte_hit[i]) begin
                    bus_rdata = q.cmp[ADDR_W-1-i*DATA_W -: DATA_W];
                end
            end
            if (stat_hit) begin
                bus_rdata[EN_BIT]  = q.en;
                bus_rdata[ACT_BIT] = q.active;
            end
        end
    end

    assign cmp_addr = q.cmp;
    assign en       = q.en;
    assign active   = q.active;

    a_r6_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        set_active |=> q.active);

    a_r7_flag_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !flag_clr_en) |=> q.active);
endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              instr_last,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              brk_ack,
    output logic              brk_req,
    output logic              take,
    output logic              wake_pulse
);
    import bkpt_pkg::*;

    trig_t q, d;
    logic  match;
    logic  boundary;
    logic  fire;

    always_comb begin
        // A waiting processor sits between instructions.
        boundary = instr_last || wait_mode;
        match    = en && !stop_mode && !q.req && cpu_valid && (cpu_addr == cmp_addr);
        fire     = (match || q.pend) && boundary && !q.req && !stop_mode;

        d.req  = stop_mode ? 1'b0 : (q.req ? !brk_ack : fire);
        d.pend = !(stop_mode || !en) && !fire && (q.pend || (match && !boundary));
        d.wake = fire && wait_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign brk_req    = q.req;
    assign take       = q.req && brk_ack;
    assign wake_pulse = q.wake;

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !q.pend && !q.req) |=> !q.req);

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && !brk_ack && !stop_mode) |=> q.req);

    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && brk_ack) |=> !q.req);

    a_r8_stop_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> !q.req);

    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.wake |=> !q.wake);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE0C,
    parameter logic [ADDR_W-1:0] VEC_NORM  = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MON   = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              instr_last,
    input  logic              brk_ack,
    input  logic              monitor_mode,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              flag_clr_en,
    output logic              brk_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              timer_freeze,
    output logic              wake_pulse
);
    logic [ADDR_W-1:0] cmp_addr;
    logic              en;
    logic              active;
    logic              take;

    bkpt_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .set_active (take),
        .flag_clr_en(flag_clr_en),
        .cmp_addr   (cmp_addr),
        .en         (en),
        .active     (active)
    );

    bkpt_trigger #(
        .ADDR_W(ADDR_W)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cmp_addr  (cmp_addr),
        .cpu_addr  (cpu_addr),
        .cpu_valid (cpu_valid),
        .instr_last(instr_last),
        .wait_mode (wait_mode),
        .stop_mode (stop_mode),
        .brk_ack   (brk_ack),
        .brk_req   (brk_req),
        .take      (take),
        .wake_pulse(wake_pulse)
    );

    assign vec_addr     = monitor_mode ? VEC_MON : VEC_NORM;
    assign timer_freeze = active;
endmodule

// File: tb/tb_bkpt_unit.sv
`timescale 1ns/100ps
module tb_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cpu_addr = '0;
    logic        cpu_valid = 1'b0, instr_last = 1'b0, brk_ack = 1'b0;
    logic        monitor_mode = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0;
    logic        flag_clr_en = 1'b0;
    logic        brk_req, timer_freeze, wake_pulse;
    logic [15:0] vec_addr;

    always #2.5 clk = ~clk;

    bkpt_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_addr(cpu_addr), .cpu_valid(cpu_valid), .instr_last(instr_last),
        .brk_ack(brk_ack), .monitor_mode(monitor_mode), .wait_mode(wait_mode),
        .stop_mode(stop_mode), .flag_clr_en(flag_clr_en), .brk_req(brk_req),
        .vec_addr(vec_addr), .timer_freeze(timer_freeze), .wake_pulse(wake_pulse)
    );

    localparam int S_RDATA = 0, S_REQ = 1, S_FRZ = 2, S_WAKE = 3, S_VEC = 4;

    typedef struct {
        int          sig;
        logic [15:0] exp;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic logic [15:0] sample(int s);
        case (s)
            S_RDATA: return {8'h00, bus_rdata};
            S_REQ:   return {15'd0, brk_req};
            S_FRZ:   return {15'd0, timer_freeze};
            S_WAKE:  return {15'd0, wake_pulse};
            default: return vec_addr;
        endcase
    endfunction

    // Monitor: compares queued expectations in the middle of each cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [15:0] act;
            e = exp_q.pop_front();
            act = sample(e.sig);
            checks++;
            if (act !== e.exp) begin
                errors++;
                $display("FAIL %s: signal %0d got %h expected %h", e.req, e.sig, act, e.exp);
            end
        end
    end

    task automatic expect_sig(int s, logic [15:0] v, string r);
        exp_t e;
        e.sig = s; e.exp = v; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(logic [15:0] a, logic [7:0] v);
        step();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [15:0] a, logic [7:0] v, string r);
        step();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        expect_sig(S_RDATA, {8'h00, v}, r);
        step();
        bus_sel = 1'b0;
    endtask

    task automatic cpu(logic [15:0] a, logic v, logic l);
        cpu_addr = a; cpu_valid = v; instr_last = l;
    endtask

    // Acknowledge a pending request and clear the resulting active flag.
    task automatic ack_and_clear(string r);
        step(); brk_ack = 1'b1;
        step(); brk_ack = 1'b0;
        expect_sig(S_REQ, 16'd0, r);
        expect_sig(S_FRZ, 16'd1, r);
        flag_clr_en = 1'b1;
        wr_reg(16'hFE0E, 8'h80);
        flag_clr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        step();
        expect_sig(S_REQ, 16'd0, "R1");
        expect_sig(S_FRZ, 16'd0, "R1");
        rd_reg(16'hFE0C, 8'h00, "R1");
        rd_reg(16'hFE0D, 8'h00, "R1");
        rd_reg(16'hFE0E, 8'h00, "R1");

        // R2 register map
        wr_reg(16'hFE0C, 8'h12);
        wr_reg(16'hFE0D, 8'h34);
        rd_reg(16'hFE0C, 8'h12, "R2");
        rd_reg(16'hFE0D, 8'h34, "R2");
        wr_reg(16'hFE0E, 8'hBF);
        rd_reg(16'hFE0E, 8'h80, "R2 R7 low bits and active write-1");
        rd_reg(16'hFE0F, 8'h00, "R2");
        wr_reg(16'hFE0E, 8'h00);

        // R5 disabled: no request
        step(); cpu(16'h1234, 1'b1, 1'b1);
        step(); cpu(16'h0000, 1'b0, 1'b0);
        expect_sig(S_REQ, 16'd0, "R5");
        step();
        expect_sig(S_REQ, 16'd0, "R5");

        // R3 immediate break on last cycle
        wr_reg(16'hFE0E, 8'h80);
        step(); cpu(16'h1234, 1'b1, 1'b1);
        step(); cpu(16'h0000, 1'b0, 1'b0);
        expect_sig(S_REQ, 16'd1, "R3");
        // R6 held without ack, dropped after ack
        step();
        expect_sig(S_REQ, 16'd1, "R6");
        step(); brk_ack = 1'b1;
        expect_sig(S_REQ, 16'd1, "R6");
        step(); brk_ack = 1'b0;
        expect_sig(S_REQ, 16'd0, "R6");
        expect_sig(S_FRZ, 16'd1, "R6");
        rd_reg(16'hFE0E, 8'hC0, "R6");

        // R7 protection
        wr_reg(16'hFE0E, 8'h80);
        rd_reg(16'hFE0E, 8'hC0, "R7 blocked");
        flag_clr_en = 1'b1;
        wr_reg(16'hFE0E, 8'h80);
        flag_clr_en = 1'b0;
        rd_reg(16'hFE0E, 8'h80, "R7 cleared");
        step();
        expect_sig(S_FRZ, 16'd0, "R7");

        // R4 deferred break
        step(); cpu(16'h1234, 1'b1, 1'b0);
        step(); cpu(16'h2000, 1'b1, 1'b0);
        expect_sig(S_REQ, 16'd0, "R4");
        step(); cpu(16'h2001, 1'b1, 1'b0);
        expect_sig(S_REQ, 16'd0, "R4");
        step(); cpu(16'h2002, 1'b1, 1'b1);
        step(); cpu(16'h0000, 1'b0, 1'b0);
        expect_sig(S_REQ, 16'd1, "R4");
        ack_and_clear("R4");

        // R8 stop mode
        step(); stop_mode = 1'b1; cpu(16'h1234, 1'b1, 1'b1);
        step(); stop_mode = 1'b0; cpu(16'h0000, 1'b0, 1'b0);
        expect_sig(S_REQ, 16'd0, "R8 match in stop");
        step(); cpu(16'h1234, 1'b1, 1'b0);
        step(); cpu(16'h0000, 1'b0, 1'b0); stop_mode = 1'b1;
        step(); stop_mode = 1'b0; instr_last = 1'b1;
        step(); instr_last = 1'b0;
        expect_sig(S_REQ, 16'd0, "R8 pending discarded");
        rd_reg(16'hFE0C, 8'h12, "R8");
        rd_reg(16'hFE0D, 8'h34, "R8");
        rd_reg(16'hFE0E, 8'h80, "R8");

        // R9 wait mode wake
        step(); wait_mode = 1'b1; cpu(16'h1234, 1'b1, 1'b0);
        step(); cpu(16'h0000, 1'b0, 1'b0);
        expect_sig(S_REQ, 16'd1, "R9");
        expect_sig(S_WAKE, 16'd1, "R9");
        step(); wait_mode = 1'b0;
        expect_sig(S_WAKE, 16'd0, "R9");
        expect_sig(S_REQ, 16'd1, "R9");
        ack_and_clear("R9");

        // R10 vector select
        step(); monitor_mode = 1'b0;
        expect_sig(S_VEC, 16'hFFFC, "R10");
        step(); monitor_mode = 1'b1;
        expect_sig(S_VEC, 16'hFEFC, "R10");

        repeat (2) step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule